// File: doc/BRIEF.md
# Write Leveling Strobe Alignment Controller

This controller runs the write leveling search for one DRAM device. After a start pulse it switches on-die termination, lets the termination settle for a programmable number of cycles, and then probes the device one strobe edge at a time. Each probe is a single-cycle strobe pulse issued at the current delay tap. The controller waits a programmable time for the device to answer on its DQ pins. It then reduces all DQ bits to one feedback bit with an AND, so a lone glitching bit cannot fake a high level.

The search only ever adds strobe delay. The tap starts at zero and goes up by one after every probe that does not end the search. The search stops at the first probe whose feedback is 1 when the probe at the previous tap returned 0. That tap is locked, termination is released and done rises. A 1 seen at tap zero, or any 1 that does not follow a 0, does not count. If the highest tap is evaluated without a 0-to-1 step, the controller reports done together with error and returns the tap to zero. The result stays on the outputs until the next start pulse. The analog delay line and the device's mode-register setup belong to other blocks.

Top module: `wrlvl_engine`

## Requirements
- R1: While reset is held and afterwards until a start pulse, odtEn, dqsPulse, done and error are low and dlyTap is 0.
- R2: A start pulse sampled when the controller is idle or finished drives odtEn high from the next cycle. The first dqsPulse appears exactly SETTLE_CYC+1 cycles after the start edge.
- R3: Each dqsPulse lasts one cycle. The feedback for that probe is sampled FB_WAIT_CYC+1 cycles after the pulse cycle. The next pulse, if any, follows FB_WAIT_CYC+2 cycles after the previous one.
- R4: dlyTap is 0 at the first probe and rises by exactly one between consecutive probes. It never decreases during a search.
- R5: When the feedback at the current tap is 1 and the feedback at the previous tap was 0, the controller locks. From the next cycle done is high, error is low, dlyTap holds the locked tap, odtEn is low and no further strobe pulse is issued.
- R6: A feedback of 1 at tap 0, or a 1 following another 1, is not a transition, and the search continues.
- R7: If the tap at its maximum value (2^TAP_W-1) is evaluated without a lock, then from the next cycle done and error are high, dlyTap is 0 and odtEn is low.
- R8: The feedback bit is the AND of all DQ_W bits of dqFb. A 1 on only some bits reads as 0.
- R9: done, error and dlyTap hold their values until the next start pulse. A start pulse while a search is running is ignored.
- R10: A start pulse after completion clears done and error on the next cycle and begins a new search from tap 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a leveling search |
| dqFb | input | DQ_W | Level the device returns on its DQ pins |
| odtEn | output | 1 | On-die termination enable during the search |
| dqsPulse | output | 1 | One-cycle request for a strobe rising edge |
| dlyTap | output | TAP_W | Strobe delay tap applied to the delay line |
| done | output | 1 | Search finished (lock or failure) |
| error | output | 1 | Search ended without a 0-to-1 transition |

## Verification
A wrong state or counter value inside this block shows at the ports within one probe period. A miscounted settle or wait moves the next dqsPulse by at least one cycle. A tap register that skips or is not cleared shows on dlyTap at the next pulse. A lost or wrongly primed previous-feedback bit makes done rise one probe early or late. The bench models the search with plain integers and compares odtEn, dqsPulse, dlyTap, done and error on every cycle, so any such deviation is caught in the cycle where it first appears. Device feedback patterns cover a clean edge, a leading high region, all-low, all-high, partial-bit glitches and an edge at the last tap.

// File: rtl/wrlvl_pkg.sv
package wrlvl_pkg;

  typedef enum logic [2:0] {
    WL_IDLE   = 3'd0,
    WL_SETTLE = 3'd1,
    WL_PULSE  = 3'd2,
    WL_WAIT   = 3'd3,
    WL_EVAL   = 3'd4,
    WL_LOCKED = 3'd5,
    WL_FAILED = 3'd6
  } wlState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadSettle;
    logic loadWait;
    logic cntDec;
    logic tapInc;
    logic tapClr;
    logic sampleFb;
    logic primePrev;
  } wlCtl_t;

endpackage

// File: rtl/wrlvl_dpath.sv
module wrlvl_dpath
  import wrlvl_pkg::*;
#(
  parameter int DQ_W        = 8,
  parameter int TAP_W       = 5,
  parameter int SETTLE_CYC  = 12,
  parameter int FB_WAIT_CYC = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  wlCtl_t           ctl,
  input  logic [DQ_W-1:0]  dqFb,
  output logic             cntZero,
  output logic             fbNow,
  output logic             prevFb,
  output logic             tapAtMax,
  output logic [TAP_W-1:0] tap
);

  localparam int CNT_MAX = (SETTLE_CYC > FB_WAIT_CYC) ? SETTLE_CYC : FB_WAIT_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] WAIT_LOAD   = CNT_W'(FB_WAIT_CYC - 1);
  localparam logic [TAP_W-1:0] TAP_TOP     = {TAP_W{1'b1}};

  logic [CNT_W-1:0] cntQ;

  // shared interval counter for the settle and the feedback wait
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (ctl.loadSettle) begin
      cntQ <= SETTLE_LOAD;
    end else if (ctl.loadWait) begin
      cntQ <= WAIT_LOAD;
    end else if (ctl.cntDec && cntQ != '0) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  assign cntZero = (cntQ == '0);

  // all bits must agree high, a partial high is read as low
  assign fbNow = &dqFb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevFb <= 1'b1;
    end else if (ctl.primePrev) begin
      prevFb <= 1'b1;
    end else if (ctl.sampleFb) begin
      prevFb <= fbNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tap <= '0;
    end else if (ctl.tapClr) begin
      tap <= '0;
    end else if (ctl.tapInc) begin
      tap <= tap + 1'b1;
    end
  end

  assign tapAtMax = (tap == TAP_TOP);

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cntDec |-> cntQ != '0);

  // R4
  no_tap_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.tapInc |-> !tapAtMax);

endmodule

// File: rtl/wrlvl_fsm.sv
module wrlvl_fsm
  import wrlvl_pkg::*;
#(
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             cntZero,
  input  logic             fbNow,
  input  logic             prevFb,
  input  logic             tapAtMax,
  input  logic [TAP_W-1:0] tap,
  output wlCtl_t           ctl,
  output logic             odtEn,
  output logic             dqsPulse,
  output logic             done,
  output logic             error
);

  wlState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= WL_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    ctl    = '0;
    unique case (stateQ)
      WL_IDLE, WL_LOCKED, WL_FAILED: begin
        if (start) begin
          stateD         = WL_SETTLE;
          ctl.loadSettle = 1'b1;
          ctl.tapClr     = 1'b1;
          ctl.primePrev  = 1'b1;
        end
      end
      WL_SETTLE: begin
        if (cntZero) stateD = WL_PULSE;
        else         ctl.cntDec = 1'b1;
      end
      WL_PULSE: begin
        stateD       = WL_WAIT;
        ctl.loadWait = 1'b1;
      end
      WL_WAIT: begin
        if (cntZero) stateD = WL_EVAL;
        else         ctl.cntDec = 1'b1;
      end
      WL_EVAL: begin
        ctl.sampleFb = 1'b1;
        if (fbNow && !prevFb) begin
          stateD = WL_LOCKED;
        end else if (tapAtMax) begin
          stateD     = WL_FAILED;
          ctl.tapClr = 1'b1;
        end else begin
          stateD     = WL_PULSE;
          ctl.tapInc = 1'b1;
        end
      end
      default: stateD = WL_IDLE;
    endcase
  end

  assign odtEn    = (stateQ == WL_SETTLE) || (stateQ == WL_PULSE) ||
                    (stateQ == WL_WAIT)   || (stateQ == WL_EVAL);
  assign dqsPulse = (stateQ == WL_PULSE);
  assign done     = (stateQ == WL_LOCKED) || (stateQ == WL_FAILED);
  assign error    = (stateQ == WL_FAILED);

  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    dqsPulse |=> !dqsPulse);

  // R4
  tap_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == WL_EVAL && stateD == WL_PULSE) |=> tap == $past(tap) + 1'b1);

  // R5
  odt_off_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !odtEn && !dqsPulse);

  // R6
  no_tap0_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !error) |-> tap != '0);

  // R7
  fail_tap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done && tap == '0);

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done && $stable(error) && $stable(tap));

endmodule

// File: rtl/wrlvl_engine.sv
module wrlvl_engine
  import wrlvl_pkg::*;
#(
  parameter int DQ_W        = 8,
  parameter int TAP_W       = 5,
  parameter int SETTLE_CYC  = 12,
  parameter int FB_WAIT_CYC = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DQ_W-1:0]  dqFb,
  output logic             odtEn,
  output logic             dqsPulse,
  output logic [TAP_W-1:0] dlyTap,
  output logic             done,
  output logic             error
);

  wlCtl_t ctl;
  logic   cntZero, fbNow, prevFb, tapAtMax;

  wrlvl_fsm #(.TAP_W(TAP_W)) fsm_i (
    .clk(clk), .rstN(rstN), .start(start),
    .cntZero(cntZero), .fbNow(fbNow), .prevFb(prevFb),
    .tapAtMax(tapAtMax), .tap(dlyTap), .ctl(ctl),
    .odtEn(odtEn), .dqsPulse(dqsPulse), .done(done), .error(error)
  );

  wrlvl_dpath #(
    .DQ_W(DQ_W), .TAP_W(TAP_W),
    .SETTLE_CYC(SETTLE_CYC), .FB_WAIT_CYC(FB_WAIT_CYC)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dqFb(dqFb),
    .cntZero(cntZero), .fbNow(fbNow), .prevFb(prevFb),
    .tapAtMax(tapAtMax), .tap(dlyTap)
  );

endmodule

// File: tb/wrlvl_engine_tb_top.sv
module wrlvl_engine_tb_top;

  localparam int DQ_W    = 4;
  localparam int TAP_W   = 4;
  localparam int SETTLE  = 6;
  localparam int FBWAIT  = 3;
  localparam int MAXTAP  = (1 << TAP_W) - 1;
  localparam int PERIOD  = FBWAIT + 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [DQ_W-1:0]  dqFb = '0;
  logic             odtEn, dqsPulse, done, error;
  logic [TAP_W-1:0] dlyTap;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  int scnSel = 0;

  always #10 clk = ~clk;

  wrlvl_engine #(
    .DQ_W(DQ_W), .TAP_W(TAP_W), .SETTLE_CYC(SETTLE), .FB_WAIT_CYC(FBWAIT)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .dqFb(dqFb),
    .odtEn(odtEn), .dqsPulse(dqsPulse), .dlyTap(dlyTap),
    .done(done), .error(error)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // device answer for a scenario and a tap
  function automatic logic [DQ_W-1:0] fbPat(input int s, input int t);
    logic [DQ_W-1:0] v;
    case (s)
      0: v = (t >= 5) ? '1 : '0;
      1: v = (t <= 2 || t >= 9) ? '1 : '0;
      2: v = '0;
      3: v = '1;
      4: begin
        v = (t >= 7) ? '1 : '0;
        if (t == 3) v = DQ_W'(1);
        if (t == 7) v[2] = 1'b0;
      end
      default: v = (t >= MAXTAP) ? '1 : '0;
    endcase
    return v;
  endfunction

  // behavioural reference: 0 idle 1 settle 2 pulse 3 wait 4 eval 5 lock 6 fail
  int mSt = 0, mCnt = 0, mTap = 0;
  bit mPrev = 1'b1;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSt = 0; mCnt = 0; mTap = 0; mPrev = 1'b1;
    end else begin
      case (mSt)
        0, 5, 6: if (start) begin mSt = 1; mCnt = 0; mTap = 0; mPrev = 1'b1; end
        1: if (mCnt == SETTLE - 1) mSt = 2; else mCnt++;
        2: begin mSt = 3; mCnt = 0; end
        3: if (mCnt == FBWAIT - 1) mSt = 4; else mCnt++;
        4: begin
          bit fb;
          fb = (dqFb == '1);
          if (fb && !mPrev)       mSt = 5;
          else if (mTap == MAXTAP) begin mSt = 6; mTap = 0; end
          else begin mTap++; mSt = 2; end
          mPrev = fb;
        end
        default: mSt = 0;
      endcase
    end
  end

  // per-cycle comparison, then drive the device answer
  always @(negedge clk) begin
    cyc++;
    chk(odtEn == (mSt >= 1 && mSt <= 4), "R2 odtEn", odtEn, (mSt >= 1 && mSt <= 4));
    chk(dqsPulse == (mSt == 2), "R3 dqsPulse", dqsPulse, (mSt == 2));
    chk(int'(dlyTap) == mTap, "R4 dlyTap", dlyTap, mTap);
    chk(done == (mSt >= 5), "R5 done", done, (mSt >= 5));
    chk(error == (mSt == 6), "R7 error", error, (mSt == 6));
    dqFb = fbPat(scnSel, int'(dlyTap));
    if (cyc > 100000) begin
      errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic runScn(input int s, input int expTap, input bit expErr,
                        input bit midStart, input string req);
    int n, firstPulse, pulses, evals;
    scnSel = s;
    @(negedge clk); start = 1'b1;
    n = 0; firstPulse = -1; pulses = 0;
    forever begin
      @(negedge clk); n++;
      start = 1'b0;
      if (done || n > 5000) break;
      if (dqsPulse) begin
        if (firstPulse < 0) firstPulse = n;
        pulses++;
      end
      if (midStart && n == 20) start = 1'b1;
    end
    evals = expErr ? MAXTAP + 1 : expTap + 1;
    chk(firstPulse == SETTLE + 1, "R2 first pulse delay", firstPulse, SETTLE + 1);
    chk(pulses == evals, {req, " pulse count"}, pulses, evals);
    chk(n == SETTLE + evals * PERIOD + 1, "R3 done timing", n, SETTLE + evals * PERIOD + 1);
    chk(int'(dlyTap) == expTap, {req, " final tap"}, dlyTap, expTap);
    chk(error == expErr, {req, " error"}, error, expErr);
    chk(odtEn == 1'b0, {req, " odt released"}, odtEn, 0);
    repeat (6) @(negedge clk);
    chk(done && int'(dlyTap) == expTap && error == expErr, "R9 result held",
        dlyTap, expTap);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!odtEn && !dqsPulse && !done && !error && dlyTap == '0, "R1 reset", done, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(!odtEn && !done && dlyTap == '0, "R1 idle after reset", odtEn, 0);

    runScn(0, 5, 1'b0, 1'b0, "R5 clean edge");
    runScn(1, 9, 1'b0, 1'b0, "R6 leading high");
    runScn(3, 0, 1'b1, 1'b0, "R6 always high");
    runScn(2, 0, 1'b1, 1'b0, "R7 always low");
    runScn(4, 8, 1'b0, 1'b0, "R8 partial bits");
    runScn(5, MAXTAP, 1'b0, 1'b0, "R5 edge at last tap");
    runScn(0, 5, 1'b0, 1'b1, "R9 start while busy");

    // restart clears the previous result on the next cycle
    scnSel = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!done && !error && odtEn && dlyTap == '0, "R10 restart clears", done, 0);
    repeat (80) @(negedge clk);
    chk(done && !error && dlyTap == 4'd5, "R10 restart locks", dlyTap, 5);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule